// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

A parallel-in, serial-out shift register rebuilt as fully synchronous logic. It runs on a fast system clock and treats its shift clock, clock-inhibit, serial and shift/load pins as ordinary asynchronous signals. Each of these pins passes through a two-flop synchronizer. The shift clock is the logical OR of the clock pin and the inhibit pin. A shift happens in the one system cycle in which that synchronized OR goes from 0 to 1.

Pulling the active-low shift/load pin low makes every stage follow the parallel inputs. This load is level-sensitive and takes priority over everything else. When shift/load is high, each effective rising edge moves the stages one place toward the last stage, and the serial bit enters the first stage. The last stage and its complement are driven as outputs. All stage values are also brought out so they can be observed.

Top module: `pload_shifter`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, every stage is cleared and the edge history is cleared. After each reset edge, `stage_out` is 0, `q_last` is 0 and `q_last_n` is 1.
- R2: While `load_n` is low, `stage_out` follows `par_in` bit for bit. Bit 0 is the first stage (A) and bit WIDTH-1 is the last stage (H). This holds whatever `sclk_in`, `inhibit_in` and `ser_in` do, and it tracks changes on `par_in` for as long as the load is held.
- R3: With `load_n` high and `inhibit_in` low, a rising edge on `sclk_in` shifts the register once. The serial bit goes into bit 0, and each bit i moves to bit i+1.
- R4: With `load_n` high and `sclk_in` low, a rising edge on `inhibit_in` also shifts the register once, exactly like R3.
- R5: While `inhibit_in` is high, rising and falling edges on `sclk_in` do not change any stage.
- R6: With `load_n` high and no rising edge of the OR of `sclk_in` and `inhibit_in` (including falling edges of either pin), all stages keep their values.
- R7: `q_last` equals stage WIDTH-1 at all times, and `q_last_n` is its complement.
- R8: If `load_n` falls in the same system cycle as a rising edge of `sclk_in`, the load wins: `stage_out` equals `par_in`, and no shift is applied.
- R9: The bit shifted in is the value `ser_in` held before the clock edge. If `ser_in` and `sclk_in` change in the same system cycle, the old serial value is the one that enters bit 0.
- R10: A change on `load_n`, `sclk_in` or `inhibit_in` reaches `stage_out` on the third rising system-clock edge after it is driven, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Shift/load control; low loads the parallel inputs |
| sclk_in | input | 1 | Shift clock pin, asynchronous |
| inhibit_in | input | 1 | Clock-inhibit pin, interchangeable with `sclk_in` |
| ser_in | input | 1 | Serial data in, enters bit 0 |
| par_in | input | WIDTH | Parallel data; bit 0 is stage A |
| q_last | output | 1 | Last stage value |
| q_last_n | output | 1 | Complement of the last stage |
| stage_out | output | WIDTH | All stage values; bit 0 is stage A |

## Verification
A wrong stage value reaches `stage_out` three system cycles after the pin change that caused it. It reaches `q_last` only after the error has been shifted up to the last stage. For that reason the bench compares all stages, not just the serial outputs.

A missed or doubled edge detection leaves the whole word one place off. This shows up at the first comparison after the shift. A synchronizer that is too short or too long shows up in the exact-cycle latency check. The wrong serial sample shows up when the serial pin and the clock pin change together.

// File: rtl/pload_shifter.sv
module pload_shifter #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             sclk_in,
  input  logic             inhibit_in,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_last,
  output logic             q_last_n,
  output logic [WIDTH-1:0] stage_out
);

  localparam int LAST = WIDTH - 1;
  localparam int SLAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] load_pipe, clk_pipe, inh_pipe, ser_pipe;
  logic [WIDTH-1:0] stages;
  logic load_s, clk_s, inh_s, ser_s, ser_d;
  logic gate_now, gate_prev, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pipe <= '1;
      clk_pipe  <= '0;
      inh_pipe  <= '0;
      ser_pipe  <= '0;
    end else begin
      load_pipe <= {load_pipe[SYNC_STAGES-2:0], load_n};
      clk_pipe  <= {clk_pipe[SYNC_STAGES-2:0], sclk_in};
      inh_pipe  <= {inh_pipe[SYNC_STAGES-2:0], inhibit_in};
      ser_pipe  <= {ser_pipe[SYNC_STAGES-2:0], ser_in};
    end
  end

  assign load_s = load_pipe[SLAST];
  assign clk_s  = clk_pipe[SLAST];
  assign inh_s  = inh_pipe[SLAST];
  assign ser_s  = ser_pipe[SLAST];

  assign gate_now = clk_s | inh_s;
  assign edge_hit = gate_now & ~gate_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev <= 1'b0;
      ser_d     <= 1'b0;
      stages    <= '0;
    end else begin
      gate_prev <= gate_now;
      ser_d     <= ser_s;
      if (!load_s)
        stages <= par_in;
      else if (edge_hit)
        stages <= {stages[LAST-1:0], ser_d};
    end
  end

  assign q_last    = stages[LAST];
  assign q_last_n  = ~stages[LAST];
  assign stage_out = stages;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stages == '0 && !gate_prev));

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !load_s |=> stages == $past(par_in));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && load_s) |=> stages == {$past(stages[LAST-1:0]), $past(ser_d)});

  // R5
  inhibit_block_chk: assert property (@(posedge clk) disable iff (rst)
    (load_s && inh_s && gate_prev) |=> $stable(stages));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_s && !edge_hit) |=> $stable(stages));

endmodule

// File: tb/sim_pload_shifter.sv
`timescale 1ns/1ps
module sim_pload_shifter;
  logic clk = 0, rst = 1, load_n = 1, sclk_in = 0, inhibit_in = 0, ser_in = 0;
  logic [7:0] par_in = 0;
  logic q_last, q_last_n;
  logic [7:0] stage_out;
  logic [7:0] exp_s;
  int checks = 0, failures = 0;
  int seed_dummy;

  pload_shifter #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .sclk_in(sclk_in),
    .inhibit_in(inhibit_in), .ser_in(ser_in), .par_in(par_in),
    .q_last(q_last), .q_last_n(q_last_n), .stage_out(stage_out));

  always #4 clk = ~clk;

  function automatic logic [7:0] shift_model(logic [7:0] s, logic b);
    return {s[6:0], b};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    checks++;
    if (stage_out !== exp_s) begin
      failures++;
      $display("FAIL %s stage_out=%h expected=%h", tag, stage_out, exp_s);
    end
    checks++;
    if (q_last !== exp_s[7] || q_last_n !== ~exp_s[7]) begin
      failures++;
      $display("FAIL R7 (%s) q_last=%b q_last_n=%b expected=%b/%b",
               tag, q_last, q_last_n, exp_s[7], ~exp_s[7]);
    end
  endtask

  task automatic do_load(logic [7:0] p);
    load_n = 0; par_in = p; step(4);
    exp_s = p; check_all("R2 load");
    sclk_in = 1; ser_in = ~ser_in; step(4);
    check_all("R2 clk ignored");
    p = p ^ 8'h5a; par_in = p; sclk_in = 0; inhibit_in = 1; step(4);
    exp_s = p; check_all("R2 follows");
    inhibit_in = 0; step(4);
    load_n = 1; step(4);
    check_all("R2 release");
  endtask

  task automatic do_clk_shift(logic b);
    ser_in = b; step(4);
    sclk_in = 1; step(4);
    exp_s = shift_model(exp_s, b); check_all("R3 clk shift");
    sclk_in = 0; step(4);
    check_all("R6 falling clk");
  endtask

  task automatic do_inh_shift(logic b);
    ser_in = b; step(4);
    inhibit_in = 1; step(4);
    exp_s = shift_model(exp_s, b); check_all("R4 inhibit shift");
    inhibit_in = 0; step(4);
    check_all("R6 falling inhibit");
  endtask

  task automatic do_blocked(logic b);
    ser_in = b; step(4);
    sclk_in = 1; step(4);
    exp_s = shift_model(exp_s, b); check_all("R3 pre-block shift");
    inhibit_in = 1; ser_in = ~b; step(4);
    sclk_in = 0; step(4);
    sclk_in = 1; step(4);
    check_all("R5 blocked edge");
    sclk_in = 0; step(4);
    inhibit_in = 0; step(4);
    check_all("R6 inhibit release");
  endtask

  initial begin
    seed_dummy = $urandom(32'h1f2e3d4c);
    step(3);
    exp_s = 8'h00;
    check_all("R1 in reset");
    rst = 0; step(4);
    check_all("R1 after reset");

    // R10 latency for load
    load_n = 0; par_in = 8'ha5;
    step(2);
    check_all("R10 not yet");
    step(1);
    exp_s = 8'ha5; check_all("R10 third edge");
    load_n = 1; step(4);

    // R10 latency for shift
    ser_in = 1; step(4);
    sclk_in = 1; step(2);
    check_all("R10 shift not yet");
    step(1);
    exp_s = shift_model(exp_s, 1'b1); check_all("R10 shift third edge");
    sclk_in = 0; step(4);

    // R9 serial changes with the clock edge
    ser_in = 0; step(4);
    ser_in = 1; sclk_in = 1; step(4);
    exp_s = shift_model(exp_s, 1'b0); check_all("R9 old serial");
    sclk_in = 0; step(4);

    // R8 load and edge together
    load_n = 0; sclk_in = 1; par_in = 8'h3c; step(4);
    exp_s = 8'h3c; check_all("R8 load wins");
    load_n = 1; step(4);
    check_all("R8 no late shift");
    sclk_in = 0; step(4);

    // walk a single one to the last stage
    do_load(8'h00);
    do_clk_shift(1'b1);
    for (int i = 0; i < 7; i++) do_inh_shift(1'b0);

    for (int k = 0; k < 160; k++) begin
      case ($urandom_range(0, 3))
        0: do_load(8'($urandom));
        1: do_clk_shift(1'($urandom));
        2: do_inh_shift(1'($urandom));
        default: do_blocked(1'($urandom));
      endcase
    end

    // R1 reset in mid-run
    rst = 1; step(2);
    exp_s = 8'h00; check_all("R1 reset again");
    rst = 0; step(4);
    check_all("R1 released");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule